// File: doc/BRIEF.md
# Configurable PLD Output Macrocell Array

This block models the eight output cells that sit between the sum-of-products array of a small programmable logic device and its I/O pins. Each cell receives one OR-term result (`sumIn`) and turns it into a pin value, a pin enable and a feedback bit that returns to the array. Two global configuration bits choose one of three device-wide modes. Each cell also has a polarity bit and a direction bit.

The three modes differ in three ways: which cells own a flip-flop, where each output enable comes from, and how feedback reaches the array. In registered mode, cells load on the rising clock edge and the auxiliary pin B acts as an active-low shared enable. In complex mode, every cell is combinational with a product-term enable, and the two outermost feedback slots carry the auxiliary inputs in place of their own pins. In simple mode, feedback comes from the neighbouring pin. The two centre cells are fixed outputs with no feedback.

Cells are numbered 0 to `CELLS-1` from one end of the pin row to the other. The centre cells are `CELLS/2-1` and `CELLS/2`, which are cells 3 and 4 by default. Auxiliary input A sits beside cell 0 and auxiliary input B sits beside cell `CELLS-1`.

Top module: `pld_macrocell_array`

## Requirements
- R1: The mode is decoded from `modeSyn` and `modeAc0`. `modeSyn`=1 with `modeAc0`=0 selects simple mode. `modeSyn`=1 with `modeAc0`=1 selects complex mode. `modeSyn`=0 selects registered mode whatever the value of `modeAc0`.
- R2: A combinational cell drives `pinOut[i] = sumIn[i] ^ cellPol[i]`, so a polarity bit of 1 inverts the output. In simple and complex modes every cell is combinational.
- R3: In registered mode, a cell with `cellDir[i]`=0 is registered. On each rising `clk` edge it loads `sumIn[i]^cellPol[i]` and drives that stored value on `pinOut[i]`. An asynchronous low `rstN` clears all stored values to 0.
- R4: A registered cell drives `pinOe[i] = !auxInB` and `fbOut[i] = !pinOut[i]`, which is the inverted stored value.
- R5: In registered mode, a cell with `cellDir[i]`=1 is combinational (R2). It drives `pinOe[i] = termOe[i]`, and its feedback is its pin value.
- R6: In complex mode, `pinOe[i] = termOe[i] & !cellDir[i]`.
- R7: In complex mode, feedback slot 0 carries `auxInA`, slot `CELLS-1` carries `auxInB`, and every other slot carries its own pin value. A pin value is `pinOut[i]` when `pinOe[i]` is 1 and `pinIn[i]` otherwise.
- R8: In simple mode, `pinOe[i] = !cellDir[i]`, except that the two centre cells are always enabled.
- R9: In simple mode, slot 0 carries `auxInA` and slot `CELLS-1` carries `auxInB`. The two centre slots are 0. A slot below the centre takes the pin value of cell i-1, and a slot above the centre takes the pin value of cell i+1.
- R10: The stored values load only in registered mode. They hold through simple and complex mode, and after a return to registered mode they reappear on the pins before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock (auxiliary clock pin in registered mode) |
| rstN | input | 1 | Asynchronous active-low clear of the cell registers |
| modeSyn | input | 1 | Global mode bit; 0 selects registered mode |
| modeAc0 | input | 1 | Global mode bit; picks complex (1) or simple (0) when modeSyn=1 |
| cellPol | input | CELLS | Per-cell polarity, 1 inverts |
| cellDir | input | CELLS | Per-cell direction bit |
| sumIn | input | CELLS | Sum-of-products result per cell |
| termOe | input | CELLS | Product-term output enable per cell |
| auxInA | input | 1 | Auxiliary input beside cell 0 |
| auxInB | input | 1 | Auxiliary input beside cell CELLS-1; active-low shared enable in registered mode |
| pinIn | input | CELLS | External level seen on each I/O pin |
| pinOut | output | CELLS | Value each cell drives |
| pinOe | output | CELLS | Drive enable per pin |
| fbOut | output | CELLS | Feedback into the array, one slot per cell |

## Verification
In registered mode, a register load and a change of the shared enable can land in the same cycle. Feedback must also keep showing the old inverted stored value until the edge. To provoke this, the bench changes `sumIn` and raises `auxInB` on the same falling edge. Before the next rising edge it checks three things: the enables have already dropped, while the outputs and feedback still reflect the old stored value. After the edge it checks that the new value is visible while the enables stay off. A second overlap is a mode change followed by a clock edge: returning to registered mode must first expose the value held since the last load (R10).

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;

  typedef enum logic [1:0] {
    MODE_SIMPLE     = 2'd0,
    MODE_COMPLEX    = 2'd1,
    MODE_REGISTERED = 2'd2
  } glbMode_e;

  // strobes from control to datapath
  typedef struct packed {
    glbMode_e mode;
    logic     capEn;
  } cellCtl_t;

endpackage

// File: rtl/pld_mode_ctrl.sv
module pld_mode_ctrl
  import pld_cell_pkg::*;
#(
  parameter int CELLS = 8
) (
  input  logic             modeSyn,
  input  logic             modeAc0,
  input  logic [CELLS-1:0] cellDir,
  output cellCtl_t         ctl,
  output logic [CELLS-1:0] regSel,
  output logic [CELLS-1:0] pinnedOut
);

  localparam int INL = CELLS / 2 - 1;
  localparam logic [CELLS-1:0] INNER_MASK = {{(CELLS-2){1'b0}}, 2'b11} << INL;

  always_comb begin
    if (!modeSyn)     ctl.mode = MODE_REGISTERED;
    else if (modeAc0) ctl.mode = MODE_COMPLEX;
    else              ctl.mode = MODE_SIMPLE;
    ctl.capEn = (ctl.mode == MODE_REGISTERED);
    regSel    = (ctl.mode == MODE_REGISTERED) ? ~cellDir : '0;
    pinnedOut = (ctl.mode == MODE_SIMPLE) ? INNER_MASK : '0;
  end

endmodule

// File: rtl/pld_cell_datapath.sv
module pld_cell_datapath
  import pld_cell_pkg::*;
#(
  parameter int CELLS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cellCtl_t         ctl,
  input  logic [CELLS-1:0] regSel,
  input  logic [CELLS-1:0] pinnedOut,
  input  logic [CELLS-1:0] cellPol,
  input  logic [CELLS-1:0] cellDir,
  input  logic [CELLS-1:0] sumIn,
  input  logic [CELLS-1:0] termOe,
  input  logic             auxInA,
  input  logic             auxInB,
  input  logic [CELLS-1:0] pinIn,
  output logic [CELLS-1:0] pinOut,
  output logic [CELLS-1:0] pinOe,
  output logic [CELLS-1:0] fbOut
);

  localparam int INL = CELLS / 2 - 1;
  localparam int INR = CELLS / 2;

  logic [CELLS-1:0] adj;
  logic [CELLS-1:0] regQ;
  logic [CELLS-1:0] pinVal;
  logic [CELLS-1:0] regFb;
  logic             isReg;
  logic             isSimple;

  assign adj      = sumIn ^ cellPol;
  assign isReg    = (ctl.mode == MODE_REGISTERED);
  assign isSimple = (ctl.mode == MODE_SIMPLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          regQ <= '0;
    else if (ctl.capEn) regQ <= adj;
  end

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    assign pinOut[i] = regSel[i] ? regQ[i] : adj[i];
    assign pinOe[i]  = isSimple ? (pinnedOut[i] | ~cellDir[i])
                     : !isReg  ? (termOe[i] & ~cellDir[i])
                     : (regSel[i] ? ~auxInB : termOe[i]);
    assign pinVal[i] = pinOe[i] ? pinOut[i] : pinIn[i];
    assign regFb[i]  = regSel[i] ? ~regQ[i] : pinVal[i];

    if (i == 0) begin : g_edgeLo
      assign fbOut[i] = isReg ? regFb[i] : auxInA;
    end else if (i == CELLS - 1) begin : g_edgeHi
      assign fbOut[i] = isReg ? regFb[i] : auxInB;
    end else if (i == INL || i == INR) begin : g_center
      assign fbOut[i] = isReg ? regFb[i] : (isSimple ? 1'b0 : pinVal[i]);
    end else if (i < INL) begin : g_lowSide
      assign fbOut[i] = isReg ? regFb[i] : (isSimple ? pinVal[i-1] : pinVal[i]);
    end else begin : g_highSide
      assign fbOut[i] = isReg ? regFb[i] : (isSimple ? pinVal[i+1] : pinVal[i]);
    end
  end

endmodule

// File: rtl/pld_macrocell_array.sv
module pld_macrocell_array
  import pld_cell_pkg::*;
#(
  parameter int CELLS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeSyn,
  input  logic             modeAc0,
  input  logic [CELLS-1:0] cellPol,
  input  logic [CELLS-1:0] cellDir,
  input  logic [CELLS-1:0] sumIn,
  input  logic [CELLS-1:0] termOe,
  input  logic             auxInA,
  input  logic             auxInB,
  input  logic [CELLS-1:0] pinIn,
  output logic [CELLS-1:0] pinOut,
  output logic [CELLS-1:0] pinOe,
  output logic [CELLS-1:0] fbOut
);

  cellCtl_t         ctl;
  logic [CELLS-1:0] regSel;
  logic [CELLS-1:0] pinnedOut;

  pld_mode_ctrl #(.CELLS(CELLS)) u_ctrl (
    .modeSyn   (modeSyn),
    .modeAc0   (modeAc0),
    .cellDir   (cellDir),
    .ctl       (ctl),
    .regSel    (regSel),
    .pinnedOut (pinnedOut)
  );

  pld_cell_datapath #(.CELLS(CELLS)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .regSel    (regSel),
    .pinnedOut (pinnedOut),
    .cellPol   (cellPol),
    .cellDir   (cellDir),
    .sumIn     (sumIn),
    .termOe    (termOe),
    .auxInA    (auxInA),
    .auxInB    (auxInB),
    .pinIn     (pinIn),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .fbOut     (fbOut)
  );

endmodule

// File: rtl/pld_cell_checks.sv
module pld_cell_checks #(
  parameter int CELLS = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             modeSyn,
  input logic             modeAc0,
  input logic [CELLS-1:0] cellPol,
  input logic [CELLS-1:0] cellDir,
  input logic [CELLS-1:0] sumIn,
  input logic [CELLS-1:0] termOe,
  input logic             auxInA,
  input logic             auxInB,
  input logic [CELLS-1:0] pinIn,
  input logic [CELLS-1:0] pinOut,
  input logic [CELLS-1:0] pinOe,
  input logic [CELLS-1:0] fbOut
);

  localparam int INL = CELLS / 2 - 1;
  localparam int INR = CELLS / 2;

  a_r2_comb_polarity: assert property (@(posedge clk) disable iff (!rstN)
    modeSyn |-> ((pinOut ^ sumIn ^ cellPol) == '0));

  a_r3_reg_capture: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(!modeSyn) && !modeSyn)
      |-> (((pinOut ^ $past(sumIn ^ cellPol)) & ~cellDir) == '0));

  a_r4_reg_enable: assert property (@(posedge clk) disable iff (!rstN)
    !modeSyn |-> (((pinOe ^ {CELLS{~auxInB}}) & ~cellDir) == '0));

  a_r4_reg_feedback: assert property (@(posedge clk) disable iff (!rstN)
    !modeSyn |-> (((fbOut ^ ~pinOut) & ~cellDir) == '0));

  a_r6_complex_enable: assert property (@(posedge clk) disable iff (!rstN)
    (modeSyn && modeAc0) |-> (pinOe == (termOe & ~cellDir)));

  a_r7_complex_edges: assert property (@(posedge clk) disable iff (!rstN)
    (modeSyn && modeAc0) |-> (fbOut[0] == auxInA && fbOut[CELLS-1] == auxInB));

  a_r8_simple_enable: assert property (@(posedge clk) disable iff (!rstN)
    (modeSyn && !modeAc0) |-> (pinOe[INL] && pinOe[INR] && (&(pinOe | cellDir))));

  a_r9_simple_feedback: assert property (@(posedge clk) disable iff (!rstN)
    (modeSyn && !modeAc0) |-> (!fbOut[INL] && !fbOut[INR]
      && fbOut[1] == (pinOe[0] ? pinOut[0] : pinIn[0])));

endmodule

bind pld_macrocell_array pld_cell_checks #(.CELLS(CELLS)) u_checks (
  .clk     (clk),
  .rstN    (rstN),
  .modeSyn (modeSyn),
  .modeAc0 (modeAc0),
  .cellPol (cellPol),
  .cellDir (cellDir),
  .sumIn   (sumIn),
  .termOe  (termOe),
  .auxInA  (auxInA),
  .auxInB  (auxInB),
  .pinIn   (pinIn),
  .pinOut  (pinOut),
  .pinOe   (pinOe),
  .fbOut   (fbOut)
);

// File: tb/test_pld_macrocell_array.sv
module test_pld_macrocell_array;

  localparam int N = 8;
  localparam int INL = N / 2 - 1;
  localparam int INR = N / 2;

  logic         clk = 1'b0;
  logic         rstN;
  logic         syn, ac0, auxA, auxB;
  logic [N-1:0] pol, dir, sum, oeT, pinIn;
  logic [N-1:0] pinOut, pinOe, fbOut;
  logic [N-1:0] expQ;
  int           checks = 0;
  int           errors = 0;
  bit           done = 0;

  always #4 clk = ~clk;

  pld_macrocell_array #(.CELLS(N)) i_pld_macrocell_array (
    .clk(clk), .rstN(rstN), .modeSyn(syn), .modeAc0(ac0),
    .cellPol(pol), .cellDir(dir), .sumIn(sum), .termOe(oeT),
    .auxInA(auxA), .auxInB(auxB), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .fbOut(fbOut)
  );

  function automatic logic [N-1:0] pat(int k, int s);
    return N'((k * 37) + (s * 101) + ((k >> 1) * 13) + (k * s));
  endfunction

  task automatic chk(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // reference built from the requirements
  task automatic checkAll(string outTag, string oeTag, string fbTag);
    logic [N-1:0] eOut, eOe, eFb, pv;
    logic isRegM, isSimp, regCell;
    isRegM = !syn;
    isSimp = syn && !ac0;
    for (int i = 0; i < N; i++) begin
      regCell = isRegM && !dir[i];
      eOut[i] = regCell ? expQ[i] : (sum[i] ^ pol[i]);
      if (isSimp)      eOe[i] = (i == INL || i == INR) ? 1'b1 : !dir[i];
      else if (!isRegM) eOe[i] = oeT[i] && !dir[i];
      else             eOe[i] = regCell ? !auxB : oeT[i];
      pv[i] = eOe[i] ? eOut[i] : pinIn[i];
    end
    for (int i = 0; i < N; i++) begin
      if (isRegM)            eFb[i] = !dir[i] ? !expQ[i] : pv[i];
      else if (i == 0)       eFb[i] = auxA;
      else if (i == N - 1)   eFb[i] = auxB;
      else if (!isSimp)      eFb[i] = pv[i];
      else if (i == INL || i == INR) eFb[i] = 1'b0;
      else if (i < INL)      eFb[i] = pv[i-1];
      else                   eFb[i] = pv[i+1];
    end
    chk(outTag, "pinOut", pinOut, eOut);
    chk(oeTag, "pinOe", pinOe, eOe);
    chk(fbTag, "fbOut", fbOut, eFb);
  endtask

  task automatic doReset();
    rstN = 1'b0; syn = 1'b0; ac0 = 1'b1; pol = '0; dir = '0;
    sum = '1; oeT = '0; auxA = 1'b0; auxB = 1'b0; pinIn = '0;
    expQ = '0;
    repeat (3) @(negedge clk);
    #2 checkAll("R3 reset", "R4 reset", "R4 reset");
    @(negedge clk) rstN = 1'b1;
  endtask

  task automatic runSimple();
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      syn = 1'b1; ac0 = 1'b0;
      pol = pat(k, 1); dir = pat(k, 2); sum = pat(k, 3);
      oeT = pat(k, 4); pinIn = pat(k, 5); auxA = k[0]; auxB = k[1];
      #2 checkAll("R1 R2 simple", "R8", "R9");
    end
    @(negedge clk);
    dir = '1; pinIn = 8'hA5;
    #2 checkAll("R2 simple all-input", "R8 all-input", "R9 all-input");
  endtask

  task automatic runComplex();
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      syn = 1'b1; ac0 = 1'b1;
      pol = pat(k, 6); dir = pat(k, 7); sum = pat(k, 8);
      oeT = pat(k, 9); pinIn = pat(k, 10); auxA = k[1]; auxB = k[0];
      #2 checkAll("R1 R2 complex", "R6", "R7");
    end
    @(negedge clk);
    dir = '0; oeT = '1; auxA = 1'b1; auxB = 1'b0;
    #2 checkAll("R2 complex all-out", "R6 all-out", "R7 all-out");
  endtask

  task automatic runRegistered();
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      syn = 1'b0; ac0 = k[0];
      pol = pat(k, 11); dir = pat(k, 12); sum = pat(k, 13);
      oeT = pat(k, 14); pinIn = pat(k, 15); auxB = k[1]; auxA = k[2];
      @(posedge clk);
      expQ = sum ^ pol;
      #2 checkAll("R1 R3 R5", "R4 R5", "R4 R5");
    end
  endtask

  task automatic runOverlap();
    @(negedge clk);
    syn = 1'b0; ac0 = 1'b1; dir = '0; pol = 8'h0F; sum = 8'h3C; auxB = 1'b0;
    @(posedge clk);
    expQ = sum ^ pol;
    @(negedge clk);
    sum = 8'hC3; auxB = 1'b1;
    #2 checkAll("R3 overlap before edge", "R4 overlap before edge", "R4 overlap before edge");
    @(posedge clk);
    expQ = sum ^ pol;
    #2 checkAll("R3 overlap after edge", "R4 overlap after edge", "R4 overlap after edge");
  endtask

  task automatic runHold();
    @(negedge clk);
    syn = 1'b0; dir = '0; pol = '0; sum = 8'h96; auxB = 1'b0;
    @(posedge clk);
    expQ = sum ^ pol;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      syn = 1'b1; ac0 = k[0]; sum = pat(k, 20);
      #2 checkAll("R2 R10 away", "R6 R8 away", "R7 R9 away");
    end
    @(negedge clk);
    syn = 1'b0; sum = 8'h5A;
    #2 checkAll("R10 held value", "R4 R10", "R4 R10");
    @(posedge clk);
    expQ = sum ^ pol;
    #2 checkAll("R10 reload", "R4 R10", "R4 R10");
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    doReset();
    runSimple();
    runComplex();
    runRegistered();
    runOverlap();
    runHold();
    done = 1;
    summary();
    $finish;
  end

endmodule